// File: doc/BRIEF.md
# Dual-Mode Dual-Clock FIFO Flag Controller

This block is a first-in first-out buffer for 36-bit words. The write side and the read side run on independent clocks, and the depth is set by a parameter. Write and read pointers are kept in binary in their own domains. Each pointer is also registered in Gray code and passed through a multi-stage synchronizer to the opposite domain. Full, input-ready and almost-full are computed in the write domain. Empty, output-ready and almost-empty are computed in the read domain.

A run-time mode bit selects one of two read behaviours. In standard mode the ready flag on the read side means "the memory is not empty", and every word, including the first, is delivered only by an explicit read strobe. In fall-through mode a one-word output stage fetches the oldest word by itself. The ready flag then means "valid data is at the outputs", and a read strobe consumes that word. Two offset inputs define the almost-empty and almost-full thresholds.

On reset, both pointers return to the first memory location. The write side then holds its ready flag low for a fixed startup delay before it accepts writes.

Top module: `dmfifo_ctrl`

## Requirements
- R1: Reset returns both pointers to memory location 0. After a reset, the first word delivered on the read side is the first word written after that reset, and no word stored before the reset appears.
- R2: While reset is asserted, `in_rdy` is 0, `out_rdy` is 0, `ae_n` is 0 and `af_n` is 1. The two almost flags are active low.
- R3: After reset is released, `in_rdy` stays 0 through the first rising `wclk` edge and becomes 1 after the second. No write is accepted before that.
- R4: In standard mode (`fwft_sel` = 0), `out_rdy` is 1 exactly when the memory holds a word. `rdata` changes only on a rising `rclk` edge where `rd_en` = 1 and `out_rdy` = 1, and it then shows the oldest stored word.
- R5: In fall-through mode (`fwft_sel` = 1), the oldest stored word appears on `rdata` with `out_rdy` = 1 and no read request. It is held there until a rising `rclk` edge with `rd_en` = 1 consumes it.
- R6: `in_rdy` is 0 when the memory holds 2^`AW` words (the write side's view), and 1 again once a read has freed a location and the write side has seen it.
- R7: `ae_n` is 0 while the read-side word count is at or below `ae_ofs`. That count includes the word held in the output stage in fall-through mode. `af_n` is 0 while the write-side free space is at or below `af_ofs`.
- R8: A write with `in_rdy` = 0, or a read with `out_rdy` = 0, is ignored and leaves both pointers and the stored data unchanged.
- R9: The mode is the value of `fwft_sel` at the first rising `rclk` edge after reset. Later changes of `fwft_sel` have no effect until the next reset.
- R10: Words are delivered in the order they were written, with every bit intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| wrst_n | input | 1 | Write-domain reset, asynchronous, active low |
| wen | input | 1 | Write strobe |
| wdata | input | DW | Write data |
| af_ofs | input | AW+1 | Almost-full threshold, in free locations |
| in_rdy | output | 1 | 1 = a write is accepted (not full, startup delay passed) |
| af_n | output | 1 | Almost-full, active low |
| rclk | input | 1 | Read clock |
| rrst_n | input | 1 | Read-domain reset, asynchronous, active low |
| fwft_sel | input | 1 | Mode select: 0 = standard, 1 = fall-through, captured after reset |
| rd_en | input | 1 | Read strobe |
| ae_ofs | input | AW+1 | Almost-empty threshold, in words |
| rdata | output | DW | Read data |
| out_rdy | output | 1 | Standard mode: not empty. Fall-through mode: `rdata` valid |
| ae_n | output | 1 | Almost-empty, active low |

## Verification
The bench targets the startup window after reset. A controller that released the write side early would show `in_rdy` high after only one write clock. It also checks the boundary of a full memory with one extra write. A design that let that write through would overwrite the oldest word, and the readback would show the extra word.

Reads of an empty FIFO are issued and then followed by a real write. A pointer that moved on the stray read would deliver stale memory instead of the new word. Fall-through mode is checked to present its first word without a strobe and to hold it while a second word arrives. A mode flip after reset is checked to change nothing. The threshold crossings of both almost flags are sampled on the exact word that crosses them.

// File: rtl/dmf_pkg.sv
package dmf_pkg;
   typedef enum logic {
      MODE_STD  = 1'b0,
      MODE_FWFT = 1'b1
   } dmf_mode_e;

   localparam int SYNC_MIN = 2;
endpackage

// File: rtl/dmf_sync.sv
module dmf_sync #(
   parameter int W      = 5,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= '0;
            else        stg[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/dmf_mem.sv
module dmf_mem #(
   parameter int DW = 36,
   parameter int AW = 4
) (
   input  logic          wclk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] ram [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) ram[waddr] <= wdata;
   end

   assign rdata = ram[raddr];
endmodule

// File: rtl/dmf_wside.sv
module dmf_wside #(
   parameter int AW        = 4,
   parameter int START_CYC = 2
) (
   input  logic          wclk,
   input  logic          wrst_n,
   input  logic          wen,
   input  logic [AW:0]   rgray_s,
   input  logic [AW:0]   af_ofs,
   output logic          we,
   output logic [AW-1:0] waddr,
   output logic [AW:0]   wgray,
   output logic          in_rdy,
   output logic          af_n
);
   localparam int             PW      = AW + 1;
   localparam int             CW      = $clog2(START_CYC + 1);
   localparam logic [PW-1:0]  DEPTH_P = PW'(1 << AW);
   localparam logic [CW-1:0]  START_P = CW'(START_CYC);

   logic [PW-1:0] wbin, wbin_nxt, rbin_s, used, free;
   logic [CW-1:0] st_cnt;
   logic          started, full;

   always_comb begin
      for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_s >> i);
   end

   assign started  = (st_cnt == START_P);
   assign used     = wbin - rbin_s;
   assign free     = DEPTH_P - used;
   assign full     = (used == DEPTH_P);
   assign in_rdy   = started && !full;
   assign af_n     = !started || (free > af_ofs);
   assign we       = wen && in_rdy;
   assign wbin_nxt = wbin + PW'(1);
   assign waddr    = wbin[AW-1:0];

   always_ff @(posedge wclk or negedge wrst_n) begin
      if (!wrst_n) begin
         st_cnt <= '0;
         wbin   <= '0;
         wgray  <= '0;
      end else begin
         if (!started) st_cnt <= st_cnt + CW'(1);
         if (we) begin
            wbin  <= wbin_nxt;
            wgray <= wbin_nxt ^ (wbin_nxt >> 1);
         end
      end
   end
endmodule

// File: rtl/dmf_rside.sv
module dmf_rside
   import dmf_pkg::*;
#(
   parameter int DW = 36,
   parameter int AW = 4
) (
   input  logic          rclk,
   input  logic          rrst_n,
   input  logic          fwft_sel,
   input  logic          rd_en,
   input  logic [AW:0]   wgray_s,
   input  logic [AW:0]   ae_ofs,
   input  logic [DW-1:0] mem_q,
   output logic [AW-1:0] raddr,
   output logic [AW:0]   rgray,
   output logic [DW-1:0] rdata,
   output logic          out_rdy,
   output logic          ae_n,
   output dmf_mode_e     mode,
   output logic          lock
);
   localparam int PW = AW + 1;

   logic [PW-1:0] rbin, rbin_nxt, wbin_s, occ;
   logic [PW:0]   lvl;
   logic          mem_empty, pop, ov, fwft;

   always_comb begin
      for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_s >> i);
   end

   assign fwft      = (mode == MODE_FWFT);
   assign occ       = wbin_s - rbin;
   assign mem_empty = (occ == '0);
   assign pop       = fwft ? (lock && !mem_empty && (!ov || rd_en))
                           : (rd_en && !mem_empty);
   assign out_rdy   = fwft ? ov : !mem_empty;
   assign lvl       = {1'b0, occ} + (PW+1)'(fwft && ov);
   assign ae_n      = lvl > {1'b0, ae_ofs};
   assign rbin_nxt  = rbin + PW'(1);
   assign raddr     = rbin[AW-1:0];

   always_ff @(posedge rclk or negedge rrst_n) begin
      if (!rrst_n) begin
         mode  <= MODE_STD;
         lock  <= 1'b0;
         rbin  <= '0;
         rgray <= '0;
         rdata <= '0;
         ov    <= 1'b0;
      end else begin
         if (!lock) begin
            mode <= dmf_mode_e'(fwft_sel);
            lock <= 1'b1;
         end
         if (pop) begin
            rbin  <= rbin_nxt;
            rgray <= rbin_nxt ^ (rbin_nxt >> 1);
            rdata <= mem_q;
         end
         if (fwft) begin
            if (pop)        ov <= 1'b1;
            else if (rd_en) ov <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/dmfifo_ctrl.sv
module dmfifo_ctrl
   import dmf_pkg::*;
#(
   parameter int DW          = 36,
   parameter int AW          = 4,
   parameter int SYNC_STAGES = 2,
   parameter int START_CYC   = 2
) (
   input  logic          wclk,
   input  logic          wrst_n,
   input  logic          wen,
   input  logic [DW-1:0] wdata,
   input  logic [AW:0]   af_ofs,
   output logic          in_rdy,
   output logic          af_n,
   input  logic          rclk,
   input  logic          rrst_n,
   input  logic          fwft_sel,
   input  logic          rd_en,
   input  logic [AW:0]   ae_ofs,
   output logic [DW-1:0] rdata,
   output logic          out_rdy,
   output logic          ae_n
);
   localparam int PW = AW + 1;

   if (DW < 1) begin : g_bad_dw
      $error("dmfifo_ctrl: DW must be positive");
   end
   if (AW < 2 || AW > 12) begin : g_bad_aw
      $error("dmfifo_ctrl: AW must lie in 2..12");
   end
   if (SYNC_STAGES < SYNC_MIN) begin : g_bad_sync
      $error("dmfifo_ctrl: SYNC_STAGES below minimum");
   end
   if (START_CYC < 1) begin : g_bad_start
      $error("dmfifo_ctrl: START_CYC must be positive");
   end

   logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
   logic [AW-1:0] waddr, raddr;
   logic [DW-1:0] mem_q;
   logic          we, rd_lock;
   dmf_mode_e     rd_mode;

   dmf_wside #(.AW(AW), .START_CYC(START_CYC)) u_wside (
      .wclk(wclk), .wrst_n(wrst_n), .wen(wen), .rgray_s(rgray_s),
      .af_ofs(af_ofs), .we(we), .waddr(waddr), .wgray(wgray),
      .in_rdy(in_rdy), .af_n(af_n)
   );

   dmf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
      .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_s)
   );

   dmf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
      .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_s)
   );

   dmf_mem #(.DW(DW), .AW(AW)) u_mem (
      .wclk(wclk), .we(we), .waddr(waddr), .wdata(wdata),
      .raddr(raddr), .rdata(mem_q)
   );

   dmf_rside #(.DW(DW), .AW(AW)) u_rside (
      .rclk(rclk), .rrst_n(rrst_n), .fwft_sel(fwft_sel), .rd_en(rd_en),
      .wgray_s(wgray_s), .ae_ofs(ae_ofs), .mem_q(mem_q), .raddr(raddr),
      .rgray(rgray), .rdata(rdata), .out_rdy(out_rdy), .ae_n(ae_n),
      .mode(rd_mode), .lock(rd_lock)
   );
endmodule

// File: rtl/dmf_chk.sv
module dmf_chk
   import dmf_pkg::*;
#(
   parameter int DW = 36,
   parameter int AW = 4
) (
   input logic          wclk,
   input logic          wrst_n,
   input logic          rclk,
   input logic          rrst_n,
   input logic          wen,
   input logic          rd_en,
   input logic          in_rdy,
   input logic          out_rdy,
   input logic          af_n,
   input logic          ae_n,
   input logic [DW-1:0] rdata,
   input logic [AW:0]   wgray,
   input logic [AW:0]   rgray,
   input dmf_mode_e     mode,
   input logic          lock
);
   AST_PTR_RESET: assert property (@(posedge wclk) !wrst_n |-> (wgray == '0)); // R1
   AST_RST_WFLAGS: assert property (@(posedge wclk) !wrst_n |-> (!in_rdy && af_n)); // R2
   AST_RST_RFLAGS: assert property (@(posedge rclk) !rrst_n |-> (!out_rdy && !ae_n)); // R2
   AST_START_DELAY: assert property (@(posedge wclk) disable iff (!wrst_n)
      $rose(in_rdy) |-> $past(wrst_n, 2)); // R3
   AST_STD_HOLD: assert property (@(posedge rclk) disable iff (!rrst_n)
      (mode == MODE_STD && !rd_en) |=> $stable(rdata)); // R4
   AST_FWFT_HOLD: assert property (@(posedge rclk) disable iff (!rrst_n)
      (mode == MODE_FWFT && out_rdy && !rd_en) |=> (out_rdy && $stable(rdata))); // R5
   AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!wrst_n)
      (wen && !in_rdy) |=> $stable(wgray)); // R8
   AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (!rrst_n)
      (mode == MODE_STD && rd_en && !out_rdy) |=> $stable(rgray)); // R8
   AST_MODE_LOCK: assert property (@(posedge rclk) disable iff (!rrst_n)
      lock |=> $stable(mode)); // R9
endmodule

bind dmfifo_ctrl dmf_chk #(.DW(DW), .AW(AW)) u_chk (
   .wclk(wclk), .wrst_n(wrst_n), .rclk(rclk), .rrst_n(rrst_n),
   .wen(wen), .rd_en(rd_en), .in_rdy(in_rdy), .out_rdy(out_rdy),
   .af_n(af_n), .ae_n(ae_n), .rdata(rdata), .wgray(wgray),
   .rgray(rgray), .mode(rd_mode), .lock(rd_lock)
);

// File: tb/dmfifo_ctrl_bench.sv
module dmfifo_ctrl_bench;
   localparam int DW    = 36;
   localparam int AW    = 4;
   localparam int DEPTH = 1 << AW;

   logic          wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
   logic          wen = 1'b0, rd_en = 1'b0, fwft_sel = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic [AW:0]   af_ofs = 5'd3, ae_ofs = 5'd2;
   logic          in_rdy, af_n, out_rdy, ae_n;
   logic [DW-1:0] rdata;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #2 wclk = ~wclk;
   always #3 rclk = ~rclk;

   dmfifo_ctrl #(.DW(DW), .AW(AW)) u_dmfifo_ctrl (
      .wclk(wclk), .wrst_n(rst_n), .wen(wen), .wdata(wdata),
      .af_ofs(af_ofs), .in_rdy(in_rdy), .af_n(af_n),
      .rclk(rclk), .rrst_n(rst_n), .fwft_sel(fwft_sel), .rd_en(rd_en),
      .ae_ofs(ae_ofs), .rdata(rdata), .out_rdy(out_rdy), .ae_n(ae_n)
   );

   // {expected ae_n after reading this word, data word}
   localparam logic [DW:0] TBL [6] = '{
      {1'b1, 36'h0_1234_5678}, {1'b1, 36'hF_FFFF_FFFF}, {1'b1, 36'h8_0000_0001},
      {1'b0, 36'h5_A5A5_A5A5}, {1'b0, 36'hA_5A5A_5A5A}, {1'b0, 36'h0_0000_0000}
   };

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr_word(input logic [DW-1:0] d);
      @(negedge wclk); wen = 1'b1; wdata = d;
      @(negedge wclk); wen = 1'b0;
   endtask

   task automatic rd_pulse();
      @(negedge rclk); rd_en = 1'b1;
      @(negedge rclk); rd_en = 1'b0;
   endtask

   task automatic settle();
      repeat (8) @(negedge rclk);
      repeat (8) @(negedge wclk);
   endtask

   task automatic do_reset(input logic mode);
      rst_n = 1'b0; fwft_sel = mode;
      repeat (4) @(negedge wclk);
      repeat (4) @(negedge rclk);
      chk("R2 in_rdy in reset", 36'(in_rdy), 36'd0);
      chk("R2 out_rdy in reset", 36'(out_rdy), 36'd0);
      chk("R2 ae_n in reset", 36'(ae_n), 36'd0);
      chk("R2 af_n in reset", 36'(af_n), 36'd1);
      @(negedge wclk); rst_n = 1'b1;
      @(negedge wclk);
      chk("R3 in_rdy after one wclk", 36'(in_rdy), 36'd0);
      @(negedge wclk);
      chk("R3 in_rdy after two wclk", 36'(in_rdy), 36'd1);
      settle();
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge wclk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         report();
      end
   end

   initial begin
      int bad;
      do_reset(1'b0);

      // Table walk, standard mode
      foreach (TBL[i]) wr_word(TBL[i][DW-1:0]);
      settle();
      chk("R4 out_rdy with data", 36'(out_rdy), 36'd1);
      chk("R4 rdata before any read", rdata, 36'd0);
      foreach (TBL[i]) begin
         rd_pulse();
         chk("R10 read order", rdata, TBL[i][DW-1:0]);
         chk("R7 ae_n after read", 36'(ae_n), 36'(TBL[i][DW]));
      end
      settle();
      chk("R4 out_rdy when drained", 36'(out_rdy), 36'd0);

      // Read on empty is ignored
      rd_pulse();
      chk("R8 rdata after empty read", rdata, TBL[5][DW-1:0]);
      wr_word(36'h0_0000_0ABC);
      settle();
      rd_pulse();
      chk("R8 pointer kept on empty read", rdata, 36'h0_0000_0ABC);
      settle();

      // Fill to full, almost-full threshold, overflow write
      for (int i = 0; i < 12; i++) wr_word(36'(100 + i));
      settle();
      chk("R7 af_n with 4 free", 36'(af_n), 36'd1);
      wr_word(36'(112));
      chk("R7 af_n with 3 free", 36'(af_n), 36'd0);
      for (int i = 13; i < DEPTH; i++) wr_word(36'(100 + i));
      chk("R6 in_rdy when full", 36'(in_rdy), 36'd0);
      wr_word(36'h0_DEAD_BEEF);
      settle();
      bad = 0;
      for (int i = 0; i < DEPTH; i++) begin
         rd_pulse();
         if (rdata !== 36'(100 + i)) bad++;
      end
      chk("R8 overflow write ignored, R10 order", 36'(bad), 36'd0);
      settle();
      chk("R6 in_rdy after drain", 36'(in_rdy), 36'd1);
      chk("R6 out_rdy after drain", 36'(out_rdy), 36'd0);

      // Leave stale words, then reset into fall-through mode
      wr_word(36'h0_0000_0777);
      wr_word(36'h0_0000_0888);
      do_reset(1'b1);
      chk("R1 nothing visible after reset", 36'(out_rdy), 36'd0);
      wr_word(36'h0_0000_0111);
      settle();
      chk("R5 first word falls through", rdata, 36'h0_0000_0111);
      chk("R1 first word after reset", 36'(out_rdy), 36'd1);
      wr_word(36'h0_0000_0222);
      settle();
      chk("R5 head held without read", rdata, 36'h0_0000_0111);
      fwft_sel = 1'b0;
      rd_pulse();
      chk("R5 next word after consume", rdata, 36'h0_0000_0222);
      chk("R5 out_rdy still valid", 36'(out_rdy), 36'd1);
      rd_pulse();
      chk("R5 out_rdy after last consume", 36'(out_rdy), 36'd0);
      rd_pulse();
      wr_word(36'h0_0000_0333);
      settle();
      chk("R9 mode kept after select change", rdata, 36'h0_0000_0333);
      chk("R8 read while not ready ignored", 36'(out_rdy), 36'd1);

      done = 1'b1;
      report();
   end
endmodule